// File: doc/BRIEF.md
# Password-Gated Two-Wire Serial Memory Controller

This block is the slave side of a two-wire serial memory whose array can only be reached after a password check. It watches a clock line and an open-drain data line, both oversampled by the system clock. It frames each transaction from start and stop conditions and shifts bytes most significant bit first. It acknowledges by pulling the data line low in the ninth clock of a byte. A transaction opens with a command byte. Eight key bytes follow, and they are compared against one of four stored keys. The master then issues a repeated start and a poll byte. Only an acknowledged poll opens the address and data phases.

Writes collect up to one page of bytes in a staging buffer. A stop that follows at least one complete data byte commits the page to the array and starts a timed nonvolatile write cycle, during which the block refuses new commands. A stop that comes earlier abandons the write. A rejected key, a refused command or the end of a transaction always returns the controller to standby. In standby it ignores the bus until the next start condition.

Top module: `pwgate_ser_ctrl`

## Requirements
- R1: After reset the data line is released (`sda_oe_o` = 0), `busy_o` is 0, every array byte reads 0x00 and all four keys are eight bytes of 0x00.
- R2: A start condition (data falling while the clock is high) followed by a command byte, while no write cycle runs, gets an acknowledge: the line is low during the ninth clock.
- R3: Command byte bit 7 selects write (1) or read (0), and bits 1:0 select the key slot. Each of the eight key bytes that follow is acknowledged, and they are compared in order with bytes 0 to 7 of that slot.
- R4: After the eighth key byte, a repeated start and a poll byte are acknowledged only if all eight key bytes matched. The next byte is then taken as the array address and acknowledged.
- R5: When any key byte mismatched, the poll byte is not acknowledged and the controller returns to standby: later bytes are not acknowledged until a new start.
- R6: In a write, data bytes are acknowledged and staged for consecutive addresses, wrapping modulo the array depth (16). Only the first PAGE (4) bytes are kept; later ones are not acknowledged and are dropped.
- R7: A stop after at least one staged data byte writes the staged bytes into the array and holds `busy_o` high for WR_CYCLES clock cycles.
- R8: While `busy_o` is high, a command byte is not acknowledged and the controller returns to standby.
- R9: A stop before the first complete data byte of a write (during the key, poll or address phase) starts no write cycle and leaves the array unchanged.
- R10: In a read, the array bytes are shifted out most significant bit first from consecutive addresses that wrap modulo the depth. A master acknowledge continues, and a master no-acknowledge ends the transfer with the line released.
- R11: The controller drives the line only for its acknowledges and for read data bits. It never drives during bits the master sends, never in standby, and changes its drive only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line from the master |
| sda_i | input | 1 | Sensed level of the shared data line |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| busy_o | output | 1 | High while a nonvolatile write cycle runs |

## Verification
On every cycle, the assertions check four things: drive changes only while the sampled clock is low, the line is released in standby, a command seen during a write cycle is never acknowledged, and the write timer falls by exactly one per cycle. They also check that the address phase is never entered without an accepted key. The bench scenarios cover what needs a full transaction to show. These are byte values read back after commits, the dropped fifth byte of a page, wrap-around at the top address, and writes abandoned by an early stop. They also include the silence that follows a rejected key and the measured length of the busy period.

// File: rtl/pwgate_pkg.sv
package pwgate_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_KEY,
        ST_WPOLL,
        ST_POLL,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } ctl_state_e;

endpackage

// File: rtl/pwgate_line_sense.sv
module pwgate_line_sense (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [2:0] scl_sh_q;
    logic [2:0] sda_sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scl_sh_q <= 3'b111;
            sda_sh_q <= 3'b111;
        end else begin
            scl_sh_q <= {scl_sh_q[1:0], scl_i};
            sda_sh_q <= {sda_sh_q[1:0], sda_i};
        end
    end

    assign scl_o      = scl_sh_q[1];
    assign sda_o      = sda_sh_q[1];
    assign scl_rise_o = scl_sh_q[1] & ~scl_sh_q[2];
    assign scl_fall_o = ~scl_sh_q[1] & scl_sh_q[2];
    assign start_o    = scl_sh_q[1] & scl_sh_q[2] & sda_sh_q[2] & ~sda_sh_q[1];
    assign stop_o     = scl_sh_q[1] & scl_sh_q[2] & ~sda_sh_q[2] & sda_sh_q[1];
endmodule

// File: rtl/pwgate_key_bank.sv
module pwgate_key_bank #(
    parameter int KEYS      = 4,
    parameter int KEY_BYTES = 8,
    localparam int KW  = $clog2(KEYS),
    localparam int KIW = $clog2(KEY_BYTES)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [KW-1:0]  slot_i,
    input  logic [KIW-1:0] byte_i,
    output logic [7:0]     key_byte_o
);
    logic [KEYS-1:0][KEY_BYTES-1:0][7:0] key_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            key_q <= '0;
        end else begin
            key_q <= key_q;
        end
    end

    assign key_byte_o = key_q[slot_i][byte_i];
endmodule

// File: rtl/pwgate_mem_array.sv
module pwgate_mem_array #(
    parameter int DEPTH = 16,
    parameter int PAGE  = 4,
    localparam int AW  = $clog2(DEPTH),
    localparam int PCW = $clog2(PAGE + 1)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [AW-1:0]             rd_addr_i,
    output logic [7:0]                rd_data_o,
    input  logic                      commit_i,
    input  logic [AW-1:0]             base_i,
    input  logic [PCW-1:0]            count_i,
    input  logic [PAGE-1:0][7:0]      page_i
);
    logic [DEPTH-1:0][7:0] cell_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cell_q <= '0;
        end else if (commit_i) begin
            for (int i = 0; i < PAGE; i++) begin
                if (i < int'(count_i)) begin
                    cell_q[AW'(int'(base_i) + i)] <= page_i[i];
                end
            end
        end
    end

    assign rd_data_o = cell_q[rd_addr_i];
endmodule

// File: rtl/pwgate_ser_ctrl.sv
module pwgate_ser_ctrl #(
    parameter int DEPTH     = 16,
    parameter int PAGE      = 4,
    parameter int KEYS      = 4,
    parameter int KEY_BYTES = 8,
    parameter int WR_CYCLES = 2000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    output logic busy_o
);
    import pwgate_pkg::*;

    localparam int AW  = $clog2(DEPTH);
    localparam int PCW = $clog2(PAGE + 1);
    localparam int PIW = $clog2(PAGE);
    localparam int KW  = $clog2(KEYS);
    localparam int KIW = $clog2(KEY_BYTES);
    localparam int KBW = $clog2(KEY_BYTES + 1);
    localparam int CW  = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        ctl_state_e            state;
        logic [3:0]            bitcnt;
        logic [7:0]            shreg;
        logic                  drive;
        logic                  is_write;
        logic [KW-1:0]         slot;
        logic [KBW-1:0]        kbyte;
        logic                  match;
        logic                  accept;
        logic                  mack;
        logic [AW-1:0]         addr;
        logic [7:0]            txb;
        logic [PCW-1:0]        wcnt;
        logic [PAGE-1:0][7:0]  wbuf;
        logic [CW-1:0]         busy_cnt;
    } ctl_t;

    ctl_t q, n;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0] key_byte;
    logic [7:0] rd_data;
    logic [AW-1:0] rd_addr;
    logic commit_d;

    pwgate_line_sense u_sense (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    pwgate_key_bank #(.KEYS(KEYS), .KEY_BYTES(KEY_BYTES)) u_keys (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .slot_i     (q.slot),
        .byte_i     (q.kbyte[KIW-1:0]),
        .key_byte_o (key_byte)
    );

    assign rd_addr = (q.state == ST_RDATA) ? q.addr + AW'(1) : q.addr;

    pwgate_mem_array #(.DEPTH(DEPTH), .PAGE(PAGE)) u_mem (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .commit_i  (commit_d),
        .base_i    (q.addr),
        .count_i   (q.wcnt),
        .page_i    (q.wbuf)
    );

    always_comb begin
        n        = q;
        commit_d = 1'b0;
        if (q.busy_cnt != '0) begin
            n.busy_cnt = q.busy_cnt - CW'(1);
        end

        if (bus_start) begin
            n.state  = (q.state == ST_WPOLL) ? ST_POLL : ST_CMD;
            n.bitcnt = '0;
            n.drive  = 1'b0;
        end else if (bus_stop) begin
            if (q.state == ST_WDATA && q.wcnt != '0 && q.busy_cnt == '0) begin
                commit_d   = 1'b1;
                n.busy_cnt = CW'(WR_CYCLES);
            end
            n.state  = ST_IDLE;
            n.bitcnt = '0;
            n.drive  = 1'b0;
        end else if (q.state != ST_IDLE) begin
            if (scl_rise) begin
                if (q.bitcnt < 4'd8) begin
                    n.shreg  = {q.shreg[6:0], sda_s};
                    n.bitcnt = q.bitcnt + 4'd1;
                end else if (q.bitcnt == 4'd8) begin
                    n.bitcnt = 4'd9;
                    n.mack   = ~sda_s;
                end
            end else if (scl_fall) begin
                if (q.bitcnt == 4'd8) begin
                    // byte boundary: decide on the acknowledge
                    n.drive = 1'b0;
                    case (q.state)
                        ST_CMD: begin
                            if (q.busy_cnt == '0) begin
                                n.drive    = 1'b1;
                                n.is_write = q.shreg[7];
                                n.slot     = q.shreg[KW-1:0];
                                n.kbyte    = '0;
                                n.match    = 1'b1;
                                n.accept   = 1'b0;
                            end
                        end
                        ST_KEY: begin
                            n.drive = 1'b1;
                            n.match = q.match & (q.shreg == key_byte);
                            n.kbyte = q.kbyte + KBW'(1);
                        end
                        ST_POLL: n.drive = q.accept;
                        ST_ADDR: begin
                            n.drive = 1'b1;
                            n.addr  = q.shreg[AW-1:0];
                        end
                        ST_WDATA: begin
                            if (q.wcnt < PCW'(PAGE)) begin
                                n.drive = 1'b1;
                                n.wbuf[q.wcnt[PIW-1:0]] = q.shreg;
                                n.wcnt  = q.wcnt + PCW'(1);
                            end
                        end
                        default: ;
                    endcase
                end else if (q.bitcnt == 4'd9) begin
                    // end of the acknowledge slot: move on
                    n.bitcnt = '0;
                    n.drive  = 1'b0;
                    case (q.state)
                        ST_CMD:  n.state = q.drive ? ST_KEY : ST_IDLE;
                        ST_KEY: begin
                            if (q.kbyte == KBW'(KEY_BYTES)) begin
                                n.state  = ST_WPOLL;
                                n.accept = q.match;
                            end
                        end
                        ST_POLL: n.state = q.accept ? ST_ADDR : ST_IDLE;
                        ST_ADDR: begin
                            if (q.is_write) begin
                                n.state = ST_WDATA;
                                n.wcnt  = '0;
                            end else begin
                                n.state = ST_RDATA;
                                n.txb   = rd_data;
                                n.drive = ~rd_data[7];
                            end
                        end
                        ST_RDATA: begin
                            if (q.mack) begin
                                n.addr  = q.addr + AW'(1);
                                n.txb   = rd_data;
                                n.drive = ~rd_data[7];
                            end else begin
                                n.state = ST_DONE;
                            end
                        end
                        default: ;
                    endcase
                end else if (q.state == ST_RDATA && q.bitcnt != 4'd0) begin
                    n.drive = ~q.txb[3'(7 - int'(q.bitcnt))];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o = q.drive;
    assign busy_o   = (q.busy_cnt != '0);
endmodule

// File: rtl/pwgate_chk.sv
module pwgate_chk #(
    parameter int WR_CYCLES = 2000,
    localparam int CW = $clog2(WR_CYCLES + 1)
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    scl_s,
    input logic                    sda_oe_o,
    input logic                    busy_o,
    input pwgate_pkg::ctl_state_e  state,
    input logic                    accept,
    input logic [CW-1:0]           busy_cnt
);
    import pwgate_pkg::*;

    a_r11_drive_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sda_oe_o) |-> !scl_s);

    a_r11_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_IDLE) |-> !sda_oe_o);

    a_r8_busy_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && state == ST_CMD) |-> !sda_oe_o);

    a_r7_timer_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - CW'(1)));

    a_r4_addr_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(state == ST_ADDR) |-> accept);
endmodule

bind pwgate_ser_ctrl pwgate_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_s    (scl_s),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .state    (q.state),
    .accept   (q.accept),
    .busy_cnt (q.busy_cnt)
);

// File: tb/pwgate_ser_ctrl_tb.sv
module pwgate_ser_ctrl_tb;
    localparam int DEPTH = 16;
    localparam int PAGE  = 4;
    localparam int WRC   = 600;
    localparam int Q     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, busy;
    logic sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [7:0] mdl [DEPTH];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign sda_line = m_sda & ~sda_oe;

    pwgate_ser_ctrl #(.DEPTH(DEPTH), .PAGE(PAGE), .WR_CYCLES(WRC)) u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .busy_o   (busy)
    );

    task automatic check(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        wait_q(); m_sda = b;
        wait_q(); m_scl = 1'b1;
        wait_q(); r = sda_line;
        wait_q(); m_scl = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_q(); m_sda = 1'b0;
        wait_q(); m_scl = 1'b1;
        wait_q(); m_sda = 1'b1;
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], r);
            check("R11 line follows master bit", int'(r), int'(b[i]));
        end
        clk_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, r);
            d = {d[6:0], r};
        end
        clk_bit(~mack, r);
    endtask

    // start, command, eight key bytes, repeated start, poll byte
    task automatic begin_access(input logic [7:0] cmd, input int bad_at);
        logic a;
        bus_start();
        send_byte(cmd, a);
        check("R2 command ack", int'(a), 1);
        for (int k = 0; k < 8; k++) begin
            send_byte((k == bad_at) ? 8'h5A : 8'h00, a);
            check("R3 key byte ack", int'(a), 1);
        end
        bus_start();
        send_byte(cmd, a);
        if (bad_at < 8) check("R5 poll refused", int'(a), 0);
        else            check("R4 poll accepted", int'(a), 1);
    endtask

    task automatic write_txn(input logic [7:0] cmd, input int addr, input int cnt,
                             input logic [7:0] base);
        logic a;
        logic [7:0] v;
        begin_access(cmd, 8);
        send_byte(8'(addr), a);
        check("R4 address ack", int'(a), 1);
        for (int i = 0; i < cnt; i++) begin
            v = base + 8'(i * 17);
            send_byte(v, a);
            check("R6 data ack within page", int'(a), (i < PAGE) ? 1 : 0);
            if (i < PAGE) mdl[(addr + i) % DEPTH] = v;
        end
        bus_stop();
        repeat (10) @(negedge clk);
        if (cnt > 0) check("R7 busy after stop", int'(busy), 1);
        else         check("R9 no write cycle", int'(busy), 0);
    endtask

    task automatic read_txn(input logic [7:0] cmd, input int addr, input int cnt);
        logic a;
        logic [7:0] d;
        begin_access(cmd, 8);
        send_byte(8'(addr), a);
        check("R4 address ack", int'(a), 1);
        for (int i = 0; i < cnt; i++) begin
            recv_byte(i < cnt - 1, d);
            check($sformatf("R10 read byte at %0d", (addr + i) % DEPTH),
                  int'(d), int'(mdl[(addr + i) % DEPTH]));
        end
        wait_q();
        check("R10 released after master nack", int'(sda_oe), 0);
        bus_stop();
        check("R11 released in standby", int'(sda_oe), 0);
    endtask

    task automatic wait_not_busy();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic a;
        int t0;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
        repeat (10) @(negedge clk);
        check("R1 line released at reset", int'(sda_oe), 0);
        check("R1 busy low at reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // write three bytes at 3 with key slot 2
        write_txn(8'h82, 3, 3, 8'hA1);
        t0 = cyc;
        // command during the write cycle is refused, then standby
        bus_start();
        send_byte(8'h01, a);
        check("R8 command refused while busy", int'(a), 0);
        send_byte(8'h00, a);
        check("R8 standby after refusal", int'(a), 0);
        bus_stop();
        check("R7 still busy", int'(busy), 1);
        while (busy) @(posedge clk);
        check("R7 busy length", ((cyc - t0) >= WRC - 40 && (cyc - t0) <= WRC + 5) ? 1 : 0, 1);
        repeat (4) @(negedge clk);

        // read 2..6 with key slot 1, covers reset contents too (R1)
        read_txn(8'h01, 2, 5);

        // wrong key byte at position 5, slot 3
        begin_access(8'h83, 5);
        send_byte(8'h09, a);
        check("R5 no ack after rejection", int'(a), 0);
        check("R11 released after rejection", int'(sda_oe), 0);
        bus_stop();
        repeat (10) @(negedge clk);
        check("R5 no write cycle", int'(busy), 0);

        // stop right after the address byte cancels
        write_txn(8'h80, 9, 0, 8'h00);
        // stop in the middle of the key bytes cancels
        bus_start();
        send_byte(8'h81, a);
        check("R2 command ack", int'(a), 1);
        for (int k = 0; k < 3; k++) send_byte(8'h00, a);
        bus_stop();
        repeat (10) @(negedge clk);
        check("R9 mid-key stop no cycle", int'(busy), 0);

        // five bytes into a four-byte page
        write_txn(8'h80, 10, 5, 8'h30);
        wait_not_busy();
        read_txn(8'h02, 9, 7);

        // wrap at the top address
        write_txn(8'h83, 15, 2, 8'h3C);
        wait_not_busy();
        read_txn(8'h03, 15, 3);
        read_txn(8'h00, 0, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule